// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a synchronous two-port RAM. It watches the registered select, read/write and address signals of both ports and drives one active-low interrupt line per port. Each port owns one mailbox word near the top of the address space. Port A owns the second-highest address (all ones minus one). Port B owns the highest address (all ones). When one port writes the other port's mailbox word, that owner's interrupt goes active. When the owner later reads its own mailbox word, the interrupt is released.

The mailbox data is ordinary RAM content. The array stores it, and this block never touches it. A mode input turns the mailbox function off. With the mode off, both top words are plain memory and neither interrupt changes state. The address width is a parameter. The interrupt lines are registered. An access presented before a rising edge changes the line at that edge.

Top module: `mbx_irq_top`

## Requirements
- R1: A synchronous active-high reset drives both `irq_a_n` and `irq_b_n` high (inactive) at the next rising edge.
- R2: With `mbx_en` high, a port B write (`b_sel`=1, `b_wr`=1) to address all-ones-minus-one drives `irq_a_n` low at the edge that samples the access.
- R3: With `mbx_en` high, a port A read (`a_sel`=1, `a_wr`=0) of address all-ones-minus-one drives `irq_a_n` high at the edge that samples it.
- R4: With `mbx_en` high, a port A write to address all-ones drives `irq_b_n` low at the edge that samples it.
- R5: With `mbx_en` high, a port B read of address all-ones drives `irq_b_n` high at the edge that samples it.
- R6: When a set and a clear for the same interrupt are sampled in the same cycle, the interrupt ends up active (low).
- R7: While `mbx_en` is low, no access changes either interrupt line, whether it would set it or clear it.
- R8: Other accesses leave both lines unchanged. These include deselected cycles, a port writing its own mailbox, a port reading the other port's mailbox, and any access to other addresses.
- R9: An active interrupt stays low across idle cycles until its owner reads the mailbox or reset occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mbx_en | input | 1 | 1 = mailbox interrupts active, 0 = top words are plain memory |
| a_sel | input | 1 | Port A registered select, active high |
| a_wr | input | 1 | Port A registered direction, 1 = write, 0 = read |
| a_addr | input | ADDR_W | Port A registered address |
| b_sel | input | 1 | Port B registered select, active high |
| b_wr | input | 1 | Port B registered direction, 1 = write, 0 = read |
| b_addr | input | ADDR_W | Port B registered address |
| irq_a_n | output | 1 | Port A interrupt, active low |
| irq_b_n | output | 1 | Port B interrupt, active low |

## Verification
Every result of this block is due at the first rising edge after the access is presented. A single flag register lies between the port inputs and each interrupt line. The bench drives each access on the falling edge and samples the lines one time unit after the following rising edge. Every check therefore observes the state right after the edge that consumed the access. Long-lived behaviour, such as holding across idle cycles or ignoring accesses while disabled, is checked after each such cycle and before the next stimulus.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_A    = 0;
    localparam int PORT_B    = 1;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } flag_cmd_t;

    function automatic acc_kind_e classify(input logic sel, input logic wr);
        if (!sel)
            return ACC_NONE;
        else if (wr)
            return ACC_WRITE;
        else
            return ACC_READ;
    endfunction

    function automatic int peer_of(input int port);
        return NUM_PORTS - 1 - port;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PORT_IDX = 0
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_own,
    output logic              wr_peer
);
    localparam logic [ADDR_W-1:0] ADDR_MAX  = '1;
    localparam logic [ADDR_W-1:0] OWN_ADDR  = ADDR_MAX - ADDR_W'(NUM_PORTS - 1 - PORT_IDX);
    localparam logic [ADDR_W-1:0] PEER_ADDR = ADDR_MAX - ADDR_W'(PORT_IDX);

    acc_kind_e kind;

    always_comb begin
        kind    = classify(sel, wr);
        rd_own  = (kind == ACC_READ)  && (addr == OWN_ADDR);
        wr_peer = (kind == ACC_WRITE) && (addr == PEER_ADDR);
    end

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag
    import mbx_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  flag_cmd_t cmd,
    output logic      irq_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (en) begin
            if (cmd.set_req)
                pending <= 1'b1;
            else if (cmd.clr_req)
                pending <= 1'b0;
        end
    end

    assign irq_n = ~pending;

    // R2 R4 R6: a set while enabled always leaves the line active
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (en && cmd.set_req) |=> !irq_n);

    // R3 R5: a lone clear while enabled releases the line
    a_r3_clear_releases: assert property (@(posedge clk) disable iff (rst)
        (en && cmd.clr_req && !cmd.set_req) |=> irq_n);

    // R7: nothing moves while the feature is off
    a_r7_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(irq_n));

    // R9: idle cycles keep the state
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (en && !cmd.set_req && !cmd.clr_req) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mbx_en,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              irq_a_n,
    output logic              irq_b_n
);
    logic [NUM_PORTS-1:0] sel_v;
    logic [NUM_PORTS-1:0] wr_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    logic [NUM_PORTS-1:0] rd_own_v;
    logic [NUM_PORTS-1:0] wr_peer_v;
    logic [NUM_PORTS-1:0] irq_n_v;

    assign sel_v[PORT_A]  = a_sel;
    assign sel_v[PORT_B]  = b_sel;
    assign wr_v[PORT_A]   = a_wr;
    assign wr_v[PORT_B]   = b_wr;
    assign addr_v[PORT_A] = a_addr;
    assign addr_v[PORT_B] = b_addr;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam int PEER = peer_of(i);
        flag_cmd_t cmd;

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .PORT_IDX (i)
        ) u_dec (
            .sel     (sel_v[i]),
            .wr      (wr_v[i]),
            .addr    (addr_v[i]),
            .rd_own  (rd_own_v[i]),
            .wr_peer (wr_peer_v[i])
        );

        assign cmd.set_req = wr_peer_v[PEER];
        assign cmd.clr_req = rd_own_v[i];

        mbx_irq_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .en    (mbx_en),
            .cmd   (cmd),
            .irq_n (irq_n_v[i])
        );
    end

    assign irq_a_n = irq_n_v[PORT_A];
    assign irq_b_n = irq_n_v[PORT_B];

    // R1: reset leaves both lines inactive
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (irq_a_n && irq_b_n));

    // R2: port B writing A's mailbox raises A's line
    a_r2_b_write_sets_a: assert property (@(posedge clk) disable iff (rst)
        (mbx_en && b_sel && b_wr && (b_addr == {{(ADDR_W-1){1'b1}}, 1'b0})) |=> !irq_a_n);

    // R8: port A never affects its own line by writing
    a_r8_own_write_no_set: assert property (@(posedge clk) disable iff (rst)
        (irq_a_n && !(b_sel && b_wr)) |=> irq_a_n);

endmodule

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] TOP  = 16'hFFFF;
    localparam logic [ADDR_W-1:0] NEXT = 16'hFFFE;
    localparam logic [ADDR_W-1:0] LOW  = 16'hFFFD;

    logic clk = 1'b0;
    logic rst, mbx_en;
    logic a_sel, a_wr, b_sel, b_wr;
    logic [ADDR_W-1:0] a_addr, b_addr;
    logic irq_a_n, irq_b_n;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mbx_irq_top #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .mbx_en(mbx_en),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr),
        .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input logic as, input logic aw, input logic [ADDR_W-1:0] aa,
                       input logic bs, input logic bw, input logic [ADDR_W-1:0] ba);
        @(negedge clk);
        a_sel = as; a_wr = aw; a_addr = aa;
        b_sel = bs; b_wr = bw; b_addr = ba;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(0, 0, '0, 0, 0, '0);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        @(negedge clk); rst = 0;
        check("R1 reset irq_a_n", irq_a_n, 1'b1);
        check("R1 reset irq_b_n", irq_b_n, 1'b1);
    endtask

    task automatic t_left();
        cyc(0, 0, '0, 1, 1, NEXT);
        check("R2 B write sets irq_a_n", irq_a_n, 1'b0);
        check("R8 irq_b_n untouched", irq_b_n, 1'b1);
        for (int k = 0; k < 3; k++) idle();
        check("R9 irq_a_n held over idle", irq_a_n, 1'b0);
        cyc(1, 0, NEXT, 0, 0, '0);
        check("R3 A read clears irq_a_n", irq_a_n, 1'b1);
    endtask

    task automatic t_right();
        cyc(1, 1, TOP, 0, 0, '0);
        check("R4 A write sets irq_b_n", irq_b_n, 1'b0);
        check("R8 irq_a_n untouched", irq_a_n, 1'b1);
        idle(); idle();
        check("R9 irq_b_n held over idle", irq_b_n, 1'b0);
        cyc(0, 0, '0, 1, 0, TOP);
        check("R5 B read clears irq_b_n", irq_b_n, 1'b1);
    endtask

    task automatic t_ignored();
        cyc(1, 1, NEXT, 1, 1, TOP);
        check("R8 own-mailbox writes irq_a_n", irq_a_n, 1'b1);
        check("R8 own-mailbox writes irq_b_n", irq_b_n, 1'b1);
        cyc(0, 1, TOP, 0, 1, NEXT);
        check("R8 deselected writes irq_a_n", irq_a_n, 1'b1);
        check("R8 deselected writes irq_b_n", irq_b_n, 1'b1);
        cyc(1, 1, LOW, 1, 1, LOW);
        check("R8 other address irq_a_n", irq_a_n, 1'b1);
        check("R8 other address irq_b_n", irq_b_n, 1'b1);
        cyc(1, 1, TOP, 1, 1, NEXT);
        check("R8 setup both active a", irq_a_n, 1'b0);
        check("R8 setup both active b", irq_b_n, 1'b0);
        cyc(1, 0, TOP, 1, 0, NEXT);
        check("R8 peer-mailbox read keeps irq_a_n", irq_a_n, 1'b0);
        check("R8 peer-mailbox read keeps irq_b_n", irq_b_n, 1'b0);
        cyc(1, 0, NEXT, 1, 0, TOP);
        check("R3 simultaneous clear a", irq_a_n, 1'b1);
        check("R5 simultaneous clear b", irq_b_n, 1'b1);
    endtask

    task automatic t_set_wins();
        cyc(1, 0, NEXT, 1, 1, NEXT);
        check("R6 set beats clear irq_a_n", irq_a_n, 1'b0);
        cyc(1, 1, TOP, 1, 0, TOP);
        check("R6 set beats clear irq_b_n", irq_b_n, 1'b0);
        check("R6 irq_a_n still set", irq_a_n, 1'b0);
        cyc(1, 0, NEXT, 1, 0, TOP);
        check("R6 cleanup a", irq_a_n, 1'b1);
        check("R6 cleanup b", irq_b_n, 1'b1);
    endtask

    task automatic t_disabled();
        @(negedge clk); mbx_en = 0;
        cyc(1, 1, TOP, 1, 1, NEXT);
        check("R7 disabled no set a", irq_a_n, 1'b1);
        check("R7 disabled no set b", irq_b_n, 1'b1);
        mbx_en = 1;
        cyc(1, 1, TOP, 1, 1, NEXT);
        @(negedge clk); mbx_en = 0;
        cyc(1, 0, NEXT, 1, 0, TOP);
        check("R7 disabled no clear a", irq_a_n, 1'b0);
        check("R7 disabled no clear b", irq_b_n, 1'b0);
        mbx_en = 1;
        cyc(1, 0, NEXT, 1, 0, TOP);
        check("R7 re-enabled clear a", irq_a_n, 1'b1);
        check("R7 re-enabled clear b", irq_b_n, 1'b1);
    endtask

    task automatic t_reset_mid();
        cyc(1, 1, TOP, 1, 1, NEXT);
        idle();
        t_reset();
    endtask

    initial begin
        rst = 1; mbx_en = 1;
        a_sel = 0; a_wr = 0; a_addr = '0;
        b_sel = 0; b_wr = 0; b_addr = '0;
        repeat (2) @(posedge clk);
        t_reset();
        t_left();
        t_right();
        t_ignored();
        t_set_wins();
        t_disabled();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule